// File: doc/BRIEF.md
# Byte-Bus Command ROM with Two Expansion Ports

This block puts a 512K x 8 read-only array and two 8-bit general-purpose ports behind one narrow host interface. The host has an 8-bit data bus, a 3-bit register select and three active-low strobes: chip enable, write enable and output enable. To read the array, the host writes a 19-bit start address as three byte writes. It then pulses output enable repeatedly. Each pulse returns the byte at the current address, and the address moves forward by one on the trailing edge of the pulse. The same bus also reaches each port's direction register and output register, and it can return the live pin levels.

The array contents come from a fixed arithmetic function of the address, so no memory file is needed. The strobes are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and only its rising (trailing) edge acts. The data bus is modelled as a split input, output and output-enable, and each port pin is modelled as a split output, enable and input.

Top module: `cmdrom_xio`

## Requirements
- R1: After reset the address counter is 0, every direction bit is 0 (all pins undriven), and both output registers are 0.
- R2: Writing with select 1, 2 or 3 loads counter bits 7:0, 15:8 or 18:16. Select 3 uses only bus bits 2:0. The load happens on the rising edge of write enable. Reading with select 1, 2 or 3 returns that counter byte, with the unused bits zero.
- R3: Reading with select 0 returns the array byte at the counter address A. That byte is A[7:0] ^ A[15:8] ^ {5'b0, A[18:16]} ^ 8'hA5.
- R4: Each rising edge of output enable with select 0 adds one to the counter. Counter-byte writes, and reads with any other select, leave the counter unchanged apart from the load itself.
- R5: Incrementing from 19'h7FFFF gives 0.
- R6: Selects 6 and 7 write and read the direction registers of port 0 and port 1. Each pin whose direction bit is 1 is driven.
- R7: Selects 4 and 5 write the output registers of port 0 and port 1. A driven pin shows its output register bit. Reading select 4 or 5 returns the live pin levels of that port.
- R8: While chip enable is high, writes and counter increments are ignored. The port registers keep their values and keep driving the pins.
- R9: The data bus is driven only while both chip enable and output enable are low.
- R10: Strobe edges are recognised after synchronisation. A write is visible at most three clock cycles after the write-enable rising edge. Select and data must be held across the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; acts on its rising edge |
| oe_n | input | 1 | Read strobe, active low; the counter advances on its rising edge |
| rsel | input | 3 | Register select code |
| bus_in | input | 8 | Data bus, host to block |
| bus_out | output | 8 | Data bus, block to host |
| bus_oe | output | 1 | Data bus drive enable |
| p0_pin_in | input | 8 | Port 0 pin levels |
| p0_out | output | 8 | Port 0 output register |
| p0_oe | output | 8 | Port 0 per-pin drive enable |
| p1_pin_in | input | 8 | Port 1 pin levels |
| p1_out | output | 8 | Port 1 output register |
| p1_oe | output | 8 | Port 1 per-pin drive enable |

## Verification
The bench streams array bytes across a non-zero start address. A design that advanced the counter on the leading edge, or on every select, would return bytes shifted by one, or a counter read-back that has moved. It steps the counter through 7FFFE and 7FFFF into zero; a carry that leaks into the high byte would show up there. It also sets up mixed-direction ports and then holds chip enable high during writes and reads. A design that lets those strobes through would change the driven pins or the counter, and one that drove the bus while deselected would raise the bus drive enable.

// File: rtl/cmdrom_pkg.sv
package cmdrom_pkg;
    localparam int ADDR_W   = 19;
    localparam int BYTE_W   = 8;
    localparam int N_PORTS  = 2;
    localparam int N_ABYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;

    typedef enum logic [2:0] {
        SEL_ROM  = 3'd0,
        SEL_ALO  = 3'd1,
        SEL_AMID = 3'd2,
        SEL_AHI  = 3'd3,
        SEL_P0   = 3'd4,
        SEL_P1   = 3'd5,
        SEL_D0   = 3'd6,
        SEL_D1   = 3'd7
    } sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] outv;
        logic [BYTE_W-1:0] dir;
    } port_regs_t;

    // Array contents as a pure function of the address
    function automatic logic [BYTE_W-1:0] rom_byte(input logic [ADDR_W-1:0] a);
        logic [N_ABYTES*BYTE_W-1:0] ext;
        logic [BYTE_W-1:0] acc;
        ext = '0;
        ext[ADDR_W-1:0] = a;
        acc = 8'hA5;
        for (int k = 0; k < N_ABYTES; k++)
            acc = acc ^ ext[k*BYTE_W +: BYTE_W];
        return acc;
    endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], strb_n};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/addr_counter.sv
module addr_counter
    import cmdrom_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              inc,
    output logic [AW-1:0]     addr
);
    localparam int NB = (AW + BYTE_W - 1) / BYTE_W;
    localparam int EW = NB * BYTE_W;

    logic [EW-1:0] ext_cur, ext_new;

    always_comb begin
        ext_cur = '0;
        ext_cur[AW-1:0] = addr;
        ext_new = ext_cur;
        for (int k = 0; k < NB; k++)
            if (wr_idx == k[1:0]) ext_new[k*BYTE_W +: BYTE_W] = wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)        addr <= '0;
        else if (wr_en) addr <= ext_new[AW-1:0];
        else if (inc)   addr <= addr + 1'b1;
    end

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_en) |=> addr == $past(addr) + 1'b1);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_en) |=> $stable(addr));
    // R2
    hi_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 2'd2) |=> addr[15:0] == $past(addr[15:0]));
endmodule

// File: rtl/xport_bank.sv
module xport_bank
    import cmdrom_pkg::*;
#(
    parameter int NP = N_PORTS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce_n,
    input  logic                     wr_en,
    input  logic                     wr_dir,
    input  logic [$clog2(NP)-1:0]    wr_port,
    input  logic [BYTE_W-1:0]        wr_byte,
    output port_regs_t [NP-1:0]      regs
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[p] <= '0;
            end else if (wr_en && wr_port == p) begin
                if (wr_dir) regs[p].dir  <= wr_byte;
                else        regs[p].outv <= wr_byte;
            end
        end

        // R8
        deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
            ce_n |=> $stable(regs[p]));
    end
endmodule

// File: rtl/cmdrom_xio.sv
module cmdrom_xio
    import cmdrom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic [2:0] rsel,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    input  logic [7:0] p0_pin_in,
    output logic [7:0] p0_out,
    output logic [7:0] p0_oe,
    input  logic [7:0] p1_pin_in,
    output logic [7:0] p1_out,
    output logic [7:0] p1_oe
);
    logic we_rise, oe_rise;
    logic [ADDR_W-1:0] addr;
    port_regs_t [N_PORTS-1:0] pregs;
    sel_e sel;
    logic ctr_wr, ctr_inc, port_wr;

    assign sel = sel_e'(rsel);

    strobe_edge #(.STAGES(2)) u_we (.clk(clk), .rst(rst), .strb_n(we_n), .rise(we_rise));
    strobe_edge #(.STAGES(2)) u_oe (.clk(clk), .rst(rst), .strb_n(oe_n), .rise(oe_rise));

    assign ctr_wr  = we_rise && !ce_n && (sel == SEL_ALO || sel == SEL_AMID || sel == SEL_AHI);
    assign ctr_inc = oe_rise && !ce_n && (sel == SEL_ROM);
    assign port_wr = we_rise && !ce_n && rsel[2];

    addr_counter #(.AW(ADDR_W)) u_ctr (
        .clk(clk), .rst(rst), .wr_en(ctr_wr), .wr_idx(rsel[1:0] - 2'd1),
        .wr_byte(bus_in), .inc(ctr_inc), .addr(addr)
    );

    xport_bank #(.NP(N_PORTS)) u_ports (
        .clk(clk), .rst(rst), .ce_n(ce_n), .wr_en(port_wr), .wr_dir(rsel[1]),
        .wr_port(rsel[0]), .wr_byte(bus_in), .regs(pregs)
    );

    assign p0_out = pregs[0].outv;
    assign p0_oe  = pregs[0].dir;
    assign p1_out = pregs[1].outv;
    assign p1_oe  = pregs[1].dir;

    logic [23:0] addr_ext;
    assign addr_ext = {{(24-ADDR_W){1'b0}}, addr};

    always_comb begin
        unique case (sel)
            SEL_ROM:  bus_out = rom_byte(addr);
            SEL_ALO:  bus_out = addr_ext[7:0];
            SEL_AMID: bus_out = addr_ext[15:8];
            SEL_AHI:  bus_out = addr_ext[23:16];
            SEL_P0:   bus_out = p0_pin_in;
            SEL_P1:   bus_out = p1_pin_in;
            SEL_D0:   bus_out = pregs[0].dir;
            SEL_D1:   bus_out = pregs[1].dir;
            default:  bus_out = '0;
        endcase
    end

    assign bus_oe = !ce_n && !oe_n;

    // R9
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !bus_oe);
    // R8
    no_inc_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !we_rise) |=> $stable(addr));
endmodule

// File: tb/tb_cmdrom_xio.sv
module tb_cmdrom_xio;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic ce_n = 0, we_n = 1, oe_n = 1;
    logic [2:0] rsel = 0;
    logic [7:0] bus_in = 0, p0_pin_in = 0, p1_pin_in = 0;
    logic [7:0] bus_out, p0_out, p0_oe, p1_out, p1_oe;
    logic bus_oe;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdrom_xio dut (.*);

    function automatic logic [7:0] model_rom(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); rsel = s; bus_in = d; we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d, output logic oe);
        @(negedge clk); rsel = s; oe_n = 0;
        repeat (4) @(negedge clk);
        d = bus_out; oe = bus_oe;
        oe_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic o;
        chk("R1 p0_oe", p0_oe, 0); chk("R1 p1_oe", p1_oe, 0);
        chk("R1 p0_out", p0_out, 0); chk("R1 p1_out", p1_out, 0);
        chk("R9 idle bus", bus_oe, 0);
        rd(1, d, o); chk("R1 ctr lo", d, 0); chk("R9 read drives", o, 1);
        rd(3, d, o); chk("R1 ctr hi", d, 0);
        rd(6, d, o); chk("R1 dir0", d, 0);
        rd(0, d, o); chk("R3 rom@0", d, model_rom(0));
        rd(1, d, o); chk("R4 after rom read", d, 1);
    endtask

    task automatic t_load_stream();
        logic [7:0] d; logic o;
        wr(1, 8'h45); wr(2, 8'h23); wr(3, 8'hF1);
        rd(1, d, o); chk("R2 lo", d, 8'h45);
        rd(2, d, o); chk("R2 mid", d, 8'h23);
        rd(3, d, o); chk("R2 hi masked", d, 8'h01);
        for (int i = 0; i < 4; i++) begin
            rd(0, d, o); chk("R3 stream", d, model_rom(19'h12345 + i));
        end
        rd(1, d, o); chk("R4 ctr advanced", d, 8'h49);
        rd(1, d, o); chk("R4 no inc other sel", d, 8'h49);
    endtask

    task automatic t_wrap();
        logic [7:0] d; logic o;
        wr(1, 8'hFE); wr(2, 8'hFF); wr(3, 8'h07);
        rd(0, d, o); chk("R5 rom 7FFFE", d, model_rom(19'h7FFFE));
        rd(0, d, o); chk("R5 rom 7FFFF", d, model_rom(19'h7FFFF));
        rd(1, d, o); chk("R5 lo wrap", d, 0);
        rd(2, d, o); chk("R5 mid wrap", d, 0);
        rd(3, d, o); chk("R5 hi wrap", d, 0);
        rd(0, d, o); chk("R5 rom 0", d, model_rom(0));
    endtask

    task automatic t_ports();
        logic [7:0] d; logic o;
        wr(6, 8'hF0); wr(7, 8'h0F); wr(4, 8'hA5); wr(5, 8'h3C);
        chk("R6 p0_oe", p0_oe, 8'hF0); chk("R6 p1_oe", p1_oe, 8'h0F);
        chk("R7 p0_out", p0_out, 8'hA5); chk("R7 p1_out", p1_out, 8'h3C);
        rd(6, d, o); chk("R6 dir0 read", d, 8'hF0);
        rd(7, d, o); chk("R6 dir1 read", d, 8'h0F);
        p0_pin_in = 8'h5A; p1_pin_in = 8'h81;
        rd(4, d, o); chk("R7 pins0", d, 8'h5A);
        rd(5, d, o); chk("R7 pins1", d, 8'h81);
    endtask

    task automatic t_deselect();
        logic [7:0] d; logic o;
        rd(1, d, o); chk("R8 ctr before", d, 8'h01);
        ce_n = 1;
        wr(4, 8'h00); wr(6, 8'h00); wr(1, 8'h77);
        rd(0, d, o); chk("R9 deselected bus", o, 0);
        chk("R8 p0_out kept", p0_out, 8'hA5); chk("R8 p0_oe kept", p0_oe, 8'hF0);
        ce_n = 0;
        rd(1, d, o); chk("R8 ctr untouched", d, 8'h01);
        rd(6, d, o); chk("R8 dir kept", d, 8'hF0);
        @(negedge clk); oe_n = 1; chk("R9 oe high", bus_oe, 0);
    endtask

    task automatic t_latency();
        @(negedge clk); rsel = 5; bus_in = 8'h99; we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1;
        repeat (3) @(negedge clk);
        chk("R10 write latency", p1_out, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_load_stream();
        t_wrap();
        t_ports();
        t_deselect();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule